// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K words of 16 bits with separate upper and lower byte strobes. Each host request carries a word address, write data, two byte enables and a read/write flag. The block accepts one request at a time through a valid/ready handshake and turns it into a strobe sequence on the memory pins. Every timing minimum of the memory is a cycle-count parameter.

Writes form one window in which chip select, write enable and the enabled byte strobes are all low. The data bus is driven only after the memory's outputs have had time to float, and all strobes are released together on one clock edge. Reads hold chip select and output enable low until the slowest access path is covered. The block then samples the bus, masks the disabled byte lane and returns the word with a one-cycle valid pulse. A recovery phase after each access covers both the minimum cycle time and the float time of the memory's outputs before the next access may drive the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever `reqReady` is high, all five active-low memory strobes are high and `memDqOe` is low.
- R2: A request is taken only on a clock edge where `reqValid` and `reqReady` are both high. A request raised while `reqReady` is low has no effect on the memory contents.
- R3: A write (`reqWrite`=1) holds chip select, write enable and the enabled byte strobes low together for WR_LEN cycles, where WR_LEN is the largest of the write-pulse, byte-setup and (float wait + data setup) counts (5 with the defaults). All of them go high on the same edge.
- R4: During a write, `memDqOe` rises only after write enable has been low for WE_HZ_CYC cycles (default 2). It stays high, with the write data on `memDqOut`, through the last cycle of the write window.
- R5: `reqBe[0]` selects the lower lane (data bits 7:0, strobe `memLbN`) and `reqBe[1]` the upper lane (bits 15:8, strobe `memUbN`). Only the enabled lanes' strobes go low. A request with `reqBe`=00 changes no memory word and reads back zero.
- R6: A read holds chip select and output enable low with write enable high for RD_ACC_CYC cycles (default 6). It samples the bus on the last of those edges and raises `rdValid` for exactly one cycle, in which output enable is already high.
- R7: In the word returned by a read, the bits of a disabled byte lane are zero.
- R8: `memDqOe` stays low until output enable has been high for at least OE_FLOAT_CYC cycles (default 2).
- R9: After acceptance, `reqReady` stays low for RD_ACC_CYC + max(OE_FLOAT_CYC, CYCLE_MIN_CYC − RD_ACC_CYC, 1) cycles on a read (8 by default). On a write it stays low for WR_LEN + max(CYCLE_MIN_CYC − WR_LEN, 1) cycles (6 by default).
- R10: `memAddr` holds the accepted address, unchanged, for as long as chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle, request may be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rdValid | output | 1 | One-cycle pulse with read data |
| rdData | output | 16 | Read data, disabled lane zeroed |
| memAddr | output | 18 | Memory address |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memDqOut | output | 16 | Data to drive onto the bus |
| memDqOe | output | 1 | Drive enable for the data pads |
| memDqIn | input | 16 | Data sampled from the bus |

## Verification
The checker watches the pin-level protocol on every cycle. It checks that the strobes are quiet while idle, that write enable and output enable are never low together, and that the write window has its full length and closes on one edge. It also counts the float waits before any drive, and checks the single-cycle valid pulse and the stable address. Only the bench scenarios can show that data arrives in the right lanes. They show that the sample is taken late enough, since the memory model returns garbage until the access time has run out, and that a request raised while busy leaves memory untouched. They also measure the exact busy time of each access type and show that a read followed at once by a write does not collide with the memory's outputs as they float.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RECOV
  } state_t;

  // Strobes from control to datapath. sel/oe/we/drive are registered,
  // latch/sample are single-cycle pulses.
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drive;
    logic latch;
    logic sample;
  } ctl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int RD_ACC = 6,
  parameter int WR_LEN = 5,
  parameter int WE_HZ  = 2,
  parameter int RD_REC = 2,
  parameter int WR_REC = 1,
  parameter int CNT_W  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  output logic reqReady,
  output logic rdValid,
  output ctl_t ctl
);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_ACC - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] RRC_LAST = CNT_W'(RD_REC - 1);
  localparam logic [CNT_W-1:0] WRC_LAST = CNT_W'(WR_REC - 1);
  localparam logic [CNT_W-1:0] HZ_CNT   = CNT_W'(WE_HZ);

  state_t state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic isWr;
  logic selQ, oeQ, weQ, driveQ;
  logic accept, rdLast;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;
  assign rdLast   = (state == ST_READ) && (cnt == RD_LAST);

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt + 1'b1;
    case (state)
      ST_IDLE: begin
        nxtCnt = '0;
        if (reqValid) nxtState = reqWrite ? ST_WRITE : ST_READ;
      end
      ST_READ: if (cnt == RD_LAST) begin
        nxtState = ST_RECOV;
        nxtCnt   = '0;
      end
      ST_WRITE: if (cnt == WR_LAST) begin
        nxtState = ST_RECOV;
        nxtCnt   = '0;
      end
      default: if (cnt == (isWr ? WRC_LAST : RRC_LAST)) begin
        nxtState = ST_IDLE;
        nxtCnt   = '0;
      end
    endcase
  end

  // Pin strobes are decoded from the next state and registered so the
  // asynchronous memory sees glitch-free edges.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWr    <= 1'b0;
      selQ    <= 1'b0;
      oeQ     <= 1'b0;
      weQ     <= 1'b0;
      driveQ  <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      state   <= nxtState;
      cnt     <= nxtCnt;
      if (accept) isWr <= reqWrite;
      selQ    <= (nxtState == ST_READ) || (nxtState == ST_WRITE);
      oeQ     <= (nxtState == ST_READ);
      weQ     <= (nxtState == ST_WRITE);
      driveQ  <= (nxtState == ST_WRITE) && (nxtCnt >= HZ_CNT);
      rdValid <= rdLast;
    end
  end

  assign ctl = '{sel: selQ, oe: oeQ, we: weQ, drive: driveQ,
                 latch: accept, sample: rdLast};

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic [DW/8-1:0]   reqBe,
  output logic [DW-1:0]     rdData,
  output logic [AW-1:0]     memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DW/8-1:0]   laneN,
  output logic [DW-1:0]     memDqOut,
  output logic              memDqOe,
  input  logic [DW-1:0]     memDqIn
);

  localparam int LANES = DW / 8;

  logic [AW-1:0]    addrQ;
  logic [DW-1:0]    wdQ;
  logic [LANES-1:0] beQ;
  logic [DW-1:0]    laneMask;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneMask[l*8 +: 8] = {8{beQ[l]}};
    assign laneN[l]           = ~(ctl.sel & beQ[l]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdQ    <= '0;
      beQ    <= '0;
      rdData <= '0;
    end else begin
      if (ctl.latch) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
        beQ   <= reqBe;
      end
      if (ctl.sample) rdData <= memDqIn & laneMask;
    end
  end

  assign memAddr  = addrQ;
  assign memCsN   = ~ctl.sel;
  assign memOeN   = ~ctl.oe;
  assign memWeN   = ~ctl.we;
  assign memDqOut = wdQ;
  assign memDqOe  = ctl.drive;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW             = 18,
  parameter int DW             = 16,
  parameter int RD_ACC_CYC     = 6,
  parameter int WR_PULSE_CYC   = 5,
  parameter int BYTE_SETUP_CYC = 5,
  parameter int DSETUP_CYC     = 3,
  parameter int WE_HZ_CYC      = 2,
  parameter int OE_FLOAT_CYC   = 2,
  parameter int CYCLE_MIN_CYC  = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [1:0]    reqBe,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic [AW-1:0] memAddr,
  output logic          memCsN,
  output logic          memOeN,
  output logic          memWeN,
  output logic          memUbN,
  output logic          memLbN,
  output logic [DW-1:0] memDqOut,
  output logic          memDqOe,
  input  logic [DW-1:0] memDqIn
);

  localparam int WR_LEN = maxOf(maxOf(WR_PULSE_CYC, BYTE_SETUP_CYC),
                                WE_HZ_CYC + DSETUP_CYC);
  localparam int RD_REC = maxOf(maxOf(OE_FLOAT_CYC, CYCLE_MIN_CYC - RD_ACC_CYC), 1);
  localparam int WR_REC = maxOf(CYCLE_MIN_CYC - WR_LEN, 1);
  localparam int CNT_W  = $clog2(maxOf(maxOf(RD_ACC_CYC, WR_LEN),
                                       maxOf(RD_REC, WR_REC)) + 1);

  ctl_t       ctl;
  logic [1:0] laneN;

  asram_fsm #(
    .RD_ACC(RD_ACC_CYC), .WR_LEN(WR_LEN), .WE_HZ(WE_HZ_CYC),
    .RD_REC(RD_REC), .WR_REC(WR_REC), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .rdValid(rdValid), .ctl(ctl)
  );

  asram_dp #(.AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .rdData(rdData),
    .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .laneN(laneN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int AW       = 18,
  parameter int WR_LEN   = 5,
  parameter int WE_HZ    = 2,
  parameter int OE_FLOAT = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          rdValid,
  input logic [AW-1:0] memAddr,
  input logic          memCsN,
  input logic          memOeN,
  input logic          memWeN,
  input logic          memUbN,
  input logic          memLbN,
  input logic          memDqOe
);

  logic [7:0] weLowCnt, oeHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      oeHighCnt <= 8'hFF;
    end else begin
      weLowCnt  <= memWeN ? 8'd0 : ((weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 8'd1);
      oeHighCnt <= !memOeN ? 8'd0 : ((oeHighCnt == 8'hFF) ? oeHighCnt : oeHighCnt + 8'd1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && memOeN && memWeN && memUbN && memLbN && !memDqOe)); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= 8'(WR_LEN))); // R3
  AST_WR_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memCsN && memUbN && memLbN)); // R3
  AST_DRIVE_AFTER_HZ: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && memOeN && weLowCnt >= 8'(WE_HZ))); // R4
  AST_LANE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !(memUbN && memLbN) |-> !memCsN); // R5
  AST_NO_OE_WE: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R6
  AST_VALID_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> memOeN); // R6
  AST_FLOAT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (oeHighCnt >= 8'(OE_FLOAT))); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr)); // R10

endmodule

bind asram_ctrl asram_chk #(
  .AW(AW), .WR_LEN(WR_LEN), .WE_HZ(WE_HZ_CYC), .OE_FLOAT(OE_FLOAT_CYC)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rdValid(rdValid), .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN),
  .memWeN(memWeN), .memUbN(memUbN), .memLbN(memLbN), .memDqOe(memDqOe)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RD_ACC     = 6;
  localparam int OE_FLOAT   = 2;
  localparam int RD_BUSY    = 8;
  localparam int WR_BUSY    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic reqReady, rdValid;
  logic [15:0] rdData;
  logic [17:0] memAddr;
  logic memCsN, memOeN, memWeN, memUbN, memLbN, memDqOe;
  logic [15:0] memDqOut, memDqIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memUbN(memUbN), .memLbN(memLbN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int nChecks = 0, nFails = 0;
  bit reported = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] memArr [logic [17:0]];
  logic [15:0] refMem [logic [17:0]];
  logic [15:0] rdWord = '0;
  int accCnt = 0, hzCnt = 0;
  logic readSel, modelDrv, wrAct;

  function automatic logic [15:0] memWord(input logic [17:0] a);
    return memArr.exists(a) ? memArr[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] refWord(input logic [17:0] a);
    return refMem.exists(a) ? refMem[a] : 16'h0000;
  endfunction

  assign readSel  = !memCsN && !memOeN && memWeN && !(memUbN && memLbN);
  assign modelDrv = readSel || (hzCnt > 0);
  assign wrAct    = !memCsN && !memWeN && !(memUbN && memLbN);

  always @(posedge clk) begin
    accCnt <= readSel ? accCnt + 1 : 0;
    hzCnt  <= readSel ? OE_FLOAT : ((hzCnt > 0) ? hzCnt - 1 : 0);
    if (readSel) rdWord <= memWord(memAddr);
  end

  always_comb begin
    memDqIn = 16'h0000;
    if (modelDrv) memDqIn = 16'hBAD0;
    if (readSel && accCnt >= RD_ACC - 1)
      memDqIn = {memUbN ? 8'hA5 : rdWord[15:8], memLbN ? 8'h5A : rdWord[7:0]};
  end

  bit inWr = 0, addrOk = 1, lastDrv = 0;
  logic [17:0] wAddr;
  logic [15:0] pendData;
  logic [1:0]  pendLanes;

  always @(negedge clk) begin
    if (rstN && memDqOe)
      check(!modelDrv, "R8", "bus drive while memory outputs active", 32'(memDqOe), 32'd0);
    if (wrAct) begin
      if (!inWr) begin inWr = 1; addrOk = 1; wAddr = memAddr; end
      else if (memAddr != wAddr) addrOk = 0;
      pendLanes = {!memUbN, !memLbN};
      if (memDqOe) pendData = memDqOut;
      lastDrv = memDqOe;
    end else if (inWr) begin
      logic [15:0] w;
      inWr = 0;
      check(lastDrv, "R4", "data driven at write end", 32'(lastDrv), 32'd1);
      check(addrOk, "R10", "address stable in write", 32'(addrOk), 32'd1);
      w = memWord(wAddr);
      if (pendLanes[0]) w[7:0]  = pendData[7:0];
      if (pendLanes[1]) w[15:8] = pendData[15:8];
      memArr[wAddr] = w;
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] expQ[$];
  string       tagQ[$];

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      check(memOeN, "R6", "output enable high with valid", 32'(memOeN), 32'd1);
      if (expQ.size() == 0) begin
        check(0, "R6", "unexpected read valid", 32'(rdData), 32'd0);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, "read data", 32'(rdData), 32'(e));
      end
    end
  end

  task automatic doReq(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag,
                       input bit poke = 0, input logic [17:0] pokeAddr = '0);
    int n;
    logic [15:0] r;
    r = refWord(a);
    if (wr) begin
      if (be[0]) r[7:0]  = d[7:0];
      if (be[1]) r[15:8] = d[15:8];
      refMem[a] = r;
    end else begin
      expQ.push_back({be[1] ? r[15:8] : 8'h00, be[0] ? r[7:0] : 8'h00});
      tagQ.push_back(tag);
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    n = 0;
    while (!reqReady) begin
      n++;
      if (poke && n == 2) begin
        reqValid = 1; reqWrite = 1; reqAddr = pokeAddr; reqWdata = 16'h7777; reqBe = 2'b11;
      end
      if (poke && n == 3) reqValid = 0;
      @(negedge clk);
    end
    check(n == (wr ? WR_BUSY : RD_BUSY), "R9", "busy cycles", 32'(n),
          32'(wr ? WR_BUSY : RD_BUSY));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: quiet after reset
    check(reqReady, "R1", "ready after reset", 32'(reqReady), 32'd1);
    check({memCsN, memOeN, memWeN, memUbN, memLbN} == 5'h1F, "R1", "strobes idle",
          32'({memCsN, memOeN, memWeN, memUbN, memLbN}), 32'h1F);
    check(!memDqOe, "R1", "no drive idle", 32'(memDqOe), 32'd0);
    check(!rdValid, "R1", "no valid idle", 32'(rdValid), 32'd0);

    doReq(1, 18'h00000, 16'h1234, 2'b11, "R3");
    doReq(0, 18'h00000, 16'h0000, 2'b11, "R6");
    doReq(1, 18'h3FFFF, 16'hABCD, 2'b01, "R5");
    doReq(0, 18'h3FFFF, 16'h0000, 2'b11, "R5");
    doReq(1, 18'h3FFFF, 16'h5E99, 2'b10, "R5");
    doReq(0, 18'h3FFFF, 16'h0000, 2'b10, "R7");
    doReq(0, 18'h3FFFF, 16'h0000, 2'b01, "R7");
    doReq(1, 18'h00000, 16'hFFFF, 2'b00, "R5");
    doReq(0, 18'h00000, 16'h0000, 2'b11, "R5");
    doReq(0, 18'h00000, 16'h0000, 2'b00, "R5");
    // R8: read followed directly by a write
    doReq(0, 18'h3FFFF, 16'h0000, 2'b11, "R8");
    doReq(1, 18'h15555, 16'h0F0F, 2'b11, "R8");
    doReq(0, 18'h15555, 16'h0000, 2'b11, "R8");
    // R2: request raised while busy must be ignored
    doReq(1, 18'h2AAAA, 16'hC3C3, 2'b11, "R2", 1, 18'h01111);
    doReq(0, 18'h01111, 16'h0000, 2'b11, "R2");
    doReq(0, 18'h2AAAA, 16'h0000, 2'b11, "R2");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R6", "all reads returned", 32'(expQ.size()), 32'd0);
    check(reqReady && memCsN && !memDqOe, "R1", "idle at end", 32'(reqReady), 32'd1);
    report();
  end

endmodule